// File: doc/BRIEF.md
# NAND event flag unit

This unit gathers the event conditions of a NAND flash controller into one sticky flag register and drives a single interrupt line. It watches the flash ready/busy pin, where low means busy, and flags the moment the device becomes ready. It also takes single-cycle pulses from the command engine: a request that was refused because the engine was busy, an operation that finished, and an ECC failure. Each event has its own bit, so one interrupt can report several of them at once.

A refused request is held in a latch together with its device number. When the engine later drops its busy level, the unit raises a separate driver-ready event and reports that device number. Software reads and writes a small register window. It clears flags by writing ones. It masks events and the interrupt through an enable register. When the device-ready event is masked, software can poll a busy bit instead.

Top module: `nand_evt_unit`

## Requirements
- R1: After reset the flags read 0, the enables read 0xF, the status reads 0x01 while the pin is low, `irq_o` is 0 and `drdy_dev_o` is 0.
- R2: Flag bit 0 (device ready) sets when the two-stage synchronised ready/busy pin rises from 0 to 1, and only while enable bit 0 is 1. A falling pin sets nothing. The first synchronised value after reset never counts as an edge.
- R3: Status bit 0 reads 1 while the synchronised pin is low (busy) and 0 while it is high, whatever the enables are.
- R4: A `reject_i` pulse latches `reject_dev_i` and sets status bit 1 (pending). On the first clock edge where the latch is pending and `engine_busy_i` is low, the pending bit clears. If enable bit 1 is 1, flag bit 1 (driver ready) then sets and `drdy_dev_o` takes the latched device number.
- R5: With enable bit 1 at 0, a pending refusal is still consumed when the engine frees up, but flag bit 1 stays 0 and `drdy_dev_o` keeps its previous value.
- R6: A `done_i` pulse sets flag bit 2, whatever the enables are.
- R7: An `ecc_fail_i` pulse sets flag bit 3, whatever the enables are. Several flags can be set at the same time.
- R8: Writing to address 0 clears each flag whose write bit is 1. If an event arrives in the same cycle as the clear of its bit, the event wins.
- R9: `irq_o` is 1 exactly when some flag is set and its enable bit (address 1, bits 3:0, read/write) is 1.
- R10: Address map: address 0 holds the flags in bits 3:0. Address 1 holds the enables. Address 2 holds the status: bit 0 busy, bit 1 pending, and bits DEV_W+1:2 the latched device number. Address 3 reads 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rb_n_i | input | 1 | Flash ready/busy pin, low means busy (asynchronous) |
| engine_busy_i | input | 1 | Command engine busy level |
| reject_i | input | 1 | Pulse: a request was refused as busy |
| reject_dev_i | input | DEV_W | Device number of the refused request |
| done_i | input | 1 | Pulse: a started operation finished |
| ecc_fail_i | input | 1 | Pulse: ECC generation or correction failed |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| drdy_dev_o | output | DEV_W | Device number carried by the last driver-ready event |

## Verification
The checker tests these rules on every cycle:
- a done pulse always leaves bit 2 set, even when a clear lands in the same cycle;
- a clear with no competing event empties its bit;
- a disabled device-ready flag cannot appear;
- a refusal always latches;
- a pending refusal that meets a free engine with the event enabled produces flag bit 1 and the latched device number;
- an enabled done raises the interrupt.

Only the bench scenarios can show the rest:
- the pin edge direction through the synchroniser;
- that the first sample after reset is ignored;
- that a disabled driver-ready still consumes the latch;
- the register map, including the writes that must be ignored.

// File: rtl/nand_evt_pkg.sv
package nand_evt_pkg;
  localparam int unsigned NUM_EVT = 4;

  localparam int unsigned EV_DEV_RDY = 0;
  localparam int unsigned EV_DRV_RDY = 1;
  localparam int unsigned EV_DONE    = 2;
  localparam int unsigned EV_ECC     = 3;

  typedef enum logic [1:0] {
    REG_FLAGS  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_STATUS = 2'd2,
    REG_RSVD   = 2'd3
  } reg_addr_e;

  localparam logic [NUM_EVT-1:0] EN_RESET   = '1;
  // events that are suppressed at the source while disabled
  localparam logic [NUM_EVT-1:0] GATED_MASK = 4'b0011;
endpackage

// File: rtl/nand_rb_edge.sv
module nand_rb_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_n_i,
  output logic ready_o,
  output logic rise_o
);
  localparam int unsigned VLD_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [VLD_W-1:0]       vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      vld_q  <= '0;
    end else begin
      sync_q[0] <= rb_n_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
      vld_q  <= {vld_q[VLD_W-2:0], 1'b1};
    end
  end

  assign ready_o = sync_q[SYNC_STAGES-1];
  // prev_q holds a real sample only once vld_q is full
  assign rise_o  = sync_q[SYNC_STAGES-1] & ~prev_q & vld_q[VLD_W-1];
endmodule

// File: rtl/nand_busy_reject.sv
module nand_busy_reject #(
  parameter int unsigned DEV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reject_i,
  input  logic [DEV_W-1:0] reject_dev_i,
  input  logic             engine_busy_i,
  output logic             pend_o,
  output logic [DEV_W-1:0] pend_dev_o,
  output logic             fire_o
);
  logic             pend_q;
  logic [DEV_W-1:0] dev_q;

  assign fire_o = pend_q & ~engine_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dev_q  <= '0;
    end else begin
      if (reject_i) begin
        pend_q <= 1'b1;
        dev_q  <= reject_dev_i;
      end else if (fire_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pend_o     = pend_q;
  assign pend_dev_o = dev_q;
endmodule

// File: rtl/nand_evt_bank.sv
module nand_evt_bank
  import nand_evt_pkg::*;
#(
  parameter int unsigned          N     = NUM_EVT,
  parameter logic [N-1:0]         GATED = GATED_MASK,
  parameter logic [N-1:0]         EN_RV = EN_RESET
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= EN_RV;
    else if (en_we_i) en_q <= wdata_i;
  end

  for (genvar k = 0; k < N; k++) begin : g_bit
    logic set_eff;
    if (GATED[k]) begin : g_gated
      assign set_eff = set_i[k] & en_q[k];
    end else begin : g_free
      assign set_eff = set_i[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     flag_q[k] <= 1'b0;
      else if (set_eff)                flag_q[k] <= 1'b1;
      else if (clr_we_i && wdata_i[k]) flag_q[k] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign en_o    = en_q;
  assign irq_o   = |(flag_q & en_q);
endmodule

// File: rtl/nand_evt_unit.sv
module nand_evt_unit
  import nand_evt_pkg::*;
#(
  parameter int unsigned DEV_W       = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rb_n_i,
  input  logic               engine_busy_i,
  input  logic               reject_i,
  input  logic [DEV_W-1:0]   reject_dev_i,
  input  logic               done_i,
  input  logic               ecc_fail_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [NUM_EVT-1:0] reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic [DEV_W-1:0]   drdy_dev_o
);
  localparam int unsigned DEV_LSB = 2;
  localparam int unsigned DEV_MSB = DEV_LSB + DEV_W - 1;

  logic               rb_ready, rb_rise;
  logic               rej_pend, rej_fire;
  logic [DEV_W-1:0]   rej_dev;
  logic [NUM_EVT-1:0] evt_set, evt_flags, evt_en;
  logic [DEV_W-1:0]   rpt_dev_q;
  logic               wr_flags, wr_en;

  nand_rb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rb_n_i  (rb_n_i),
    .ready_o (rb_ready),
    .rise_o  (rb_rise)
  );

  nand_busy_reject #(.DEV_W(DEV_W)) u_rej (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reject_i      (reject_i),
    .reject_dev_i  (reject_dev_i),
    .engine_busy_i (engine_busy_i),
    .pend_o        (rej_pend),
    .pend_dev_o    (rej_dev),
    .fire_o        (rej_fire)
  );

  always_comb begin
    evt_set             = '0;
    evt_set[EV_DEV_RDY] = rb_rise;
    evt_set[EV_DRV_RDY] = rej_fire;
    evt_set[EV_DONE]    = done_i;
    evt_set[EV_ECC]     = ecc_fail_i;
  end

  assign wr_flags = reg_we_i && (reg_addr_i == REG_FLAGS);
  assign wr_en    = reg_we_i && (reg_addr_i == REG_ENABLE);

  nand_evt_bank #(.N(NUM_EVT), .GATED(GATED_MASK), .EN_RV(EN_RESET)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_set),
    .clr_we_i (wr_flags),
    .en_we_i  (wr_en),
    .wdata_i  (reg_wdata_i),
    .flags_o  (evt_flags),
    .en_o     (evt_en),
    .irq_o    (irq_o)
  );

  // device number reported only with a generated driver-ready event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rpt_dev_q <= '0;
    else if (rej_fire && evt_en[EV_DRV_RDY]) rpt_dev_q <= rej_dev;
  end
  assign drdy_dev_o = rpt_dev_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_FLAGS:  reg_rdata_o[NUM_EVT-1:0] = evt_flags;
      REG_ENABLE: reg_rdata_o[NUM_EVT-1:0] = evt_en;
      REG_STATUS: begin
        reg_rdata_o[0]               = ~rb_ready;
        reg_rdata_o[1]               = rej_pend;
        reg_rdata_o[DEV_MSB:DEV_LSB] = rej_dev;
      end
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/nand_evt_unit_chk.sv
module nand_evt_unit_chk
  import nand_evt_pkg::*;
#(
  parameter int unsigned DEV_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               engine_busy_i,
  input logic               reject_i,
  input logic               done_i,
  input logic               ecc_fail_i,
  input logic               reg_we_i,
  input logic [1:0]         reg_addr_i,
  input logic [NUM_EVT-1:0] reg_wdata_i,
  input logic               irq_o,
  input logic [DEV_W-1:0]   drdy_dev_o,
  input logic [NUM_EVT-1:0] flags_i,
  input logic [NUM_EVT-1:0] en_i,
  input logic               pend_i,
  input logic [DEV_W-1:0]   pend_dev_i
);
  assert_dev_rdy_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i[EV_DEV_RDY] && !flags_i[EV_DEV_RDY]) |=> !flags_i[EV_DEV_RDY]);

  assert_reject_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_i |=> pend_i);

  assert_drdy_fire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !engine_busy_i && !reject_i && en_i[EV_DRV_RDY])
      |=> (flags_i[EV_DRV_RDY] && !pend_i && drdy_dev_o == $past(pend_dev_i)));

  assert_done_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> flags_i[EV_DONE]);

  assert_ecc_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_fail_i |=> flags_i[EV_ECC]);

  assert_w1c_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[EV_ECC] && !ecc_fail_i)
      |=> !flags_i[EV_ECC]);

  assert_irq_on_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && en_i[EV_DONE] && !(reg_we_i && reg_addr_i == 2'd1)) |=> irq_o);
endmodule

bind nand_evt_unit nand_evt_unit_chk #(.DEV_W(DEV_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .engine_busy_i (engine_busy_i),
  .reject_i      (reject_i),
  .done_i        (done_i),
  .ecc_fail_i    (ecc_fail_i),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .irq_o         (irq_o),
  .drdy_dev_o    (drdy_dev_o),
  .flags_i       (evt_flags),
  .en_i          (evt_en),
  .pend_i        (rej_pend),
  .pend_dev_i    (rej_dev)
);

// File: tb/nand_evt_unit_bench.sv
module nand_evt_unit_bench;
  localparam int DEV_W  = 3;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_ni = 1'b0, rb_n = 1'b0, eng_busy = 1'b0;
  logic             reject = 1'b0, done = 1'b0, ecc = 1'b0, we = 1'b0;
  logic [DEV_W-1:0] rdev = '0;
  logic [1:0]       addr = '0;
  logic [3:0]       wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic             irq;
  logic [DEV_W-1:0] drdy_dev;

  nand_evt_unit #(.DEV_W(DEV_W), .DATA_W(DATA_W)) u_nand_evt_unit (
    .clk_i(clk), .rst_ni(rst_ni), .rb_n_i(rb_n), .engine_busy_i(eng_busy),
    .reject_i(reject), .reject_dev_i(rdev), .done_i(done), .ecc_fail_i(ecc),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .drdy_dev_o(drdy_dev)
  );

  typedef struct {
    int    kind;   // 0 register, 1 irq, 2 drdy_dev
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0:       act = int'(rdata);
        1:       act = int'(irq);
        default: act = int'(drdy_dev);
      endcase
      n_chk++;
      if (act != it.exp) begin
        n_err++;
        $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [1:0] a, input int exp, input string tag);
    @(posedge clk); #1;
    addr = a;
    q.push_back('{kind: kind, exp: exp, tag: tag});
    @(negedge clk); #1;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic pulse_done();
    @(posedge clk); #1; done = 1'b1;
    @(posedge clk); #1; done = 1'b0;
  endtask

  task automatic pulse_ecc();
    @(posedge clk); #1; ecc = 1'b1;
    @(posedge clk); #1; ecc = 1'b0;
  endtask

  task automatic pulse_reject(input logic [DEV_W-1:0] d);
    @(posedge clk); #1; reject = 1'b1; rdev = d;
    @(posedge clk); #1; reject = 1'b0;
  endtask

  task automatic do_reset(input logic rbv);
    rst_ni = 1'b0; rb_n = rbv; eng_busy = 1'b0; reject = 1'b0;
    done = 1'b0; ecc = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    tick(3);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset(1'b0);
    chk(0, 2'd0, 8'h00, "R1 flags");
    chk(0, 2'd1, 8'h0F, "R1 enables");
    chk(0, 2'd2, 8'h01, "R1 status");
    chk(1, 2'd0, 0,     "R1 irq");
    chk(2, 2'd0, 0,     "R1 drdy_dev");

    // pin rises: device ready
    rb_n = 1'b1; tick(4);
    chk(0, 2'd0, 8'h01, "R2 rise sets bit0");
    chk(0, 2'd2, 8'h00, "R3 ready status");
    chk(1, 2'd0, 1,     "R9 irq on bit0");
    wr(2'd0, 4'h1);
    chk(0, 2'd0, 8'h00, "R8 w1c bit0");
    chk(1, 2'd0, 0,     "R9 irq cleared");

    // falling pin: no event
    rb_n = 1'b0; tick(4);
    chk(0, 2'd0, 8'h00, "R2 fall no event");
    chk(0, 2'd2, 8'h01, "R3 busy status");

    // device-ready disabled, busy still pollable
    wr(2'd1, 4'hE);
    rb_n = 1'b1; tick(4);
    chk(0, 2'd0, 8'h00, "R2 disabled no event");
    chk(0, 2'd2, 8'h00, "R3 poll ready while disabled");

    // refused request, then engine frees up
    eng_busy = 1'b1; tick(1);
    pulse_reject(3'd5); tick(3);
    chk(0, 2'd0, 8'h00, "R4 no event while busy");
    chk(0, 2'd2, 8'h16, "R4 pending with dev");
    eng_busy = 1'b0; tick(3);
    chk(0, 2'd0, 8'h02, "R4 driver ready set");
    chk(2, 2'd0, 5,     "R4 drdy_dev");
    chk(0, 2'd2, 8'h14, "R4 pending cleared");
    chk(1, 2'd0, 1,     "R9 irq on bit1");

    // driver-ready disabled
    wr(2'd0, 4'h2);
    wr(2'd1, 4'hC);
    eng_busy = 1'b1; tick(1);
    pulse_reject(3'd3); tick(1);
    eng_busy = 1'b0; tick(3);
    chk(0, 2'd0, 8'h00, "R5 no driver-ready when disabled");
    chk(0, 2'd2, 8'h0C, "R5 pending consumed");
    chk(2, 2'd0, 5,     "R5 drdy_dev kept");

    // done and ECC
    pulse_done(); tick(1);
    chk(0, 2'd0, 8'h04, "R6 done sets bit2");
    chk(1, 2'd0, 1,     "R9 irq on done");
    pulse_ecc(); tick(1);
    chk(0, 2'd0, 8'h0C, "R7 ecc sets bit3, both held");
    wr(2'd1, 4'h0);
    chk(1, 2'd0, 0,     "R9 irq masked");
    chk(0, 2'd0, 8'h0C, "R9 flags kept while masked");
    wr(2'd1, 4'h8);
    chk(1, 2'd0, 1,     "R9 irq via bit3 enable");

    // clear and new event in the same cycle
    @(posedge clk); #1;
    we = 1'b1; addr = 2'd0; wdata = 4'hC; done = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; done = 1'b0;
    chk(0, 2'd0, 8'h04, "R8 set wins over clear");

    // ignored writes
    wr(2'd2, 4'hF);
    chk(0, 2'd2, 8'h0C, "R10 status write ignored");
    wr(2'd3, 4'hF);
    chk(0, 2'd3, 8'h00, "R10 reserved reads zero");
    chk(0, 2'd1, 8'h08, "R10 enables unchanged");
    chk(0, 2'd0, 8'h04, "R10 flags unchanged");

    // first sample after reset is not an edge
    do_reset(1'b1); tick(8);
    chk(0, 2'd0, 8'h00, "R2 first sample no edge");
    chk(0, 2'd2, 8'h00, "R3 ready after reset");

    tick(2);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule